// File: doc/BRIEF.md
# Backplane Bus Arbiter with Grant Timeout

This block is the arbitration part of a system controller for a shared parallel backplane. Bus masters ask for the bus on four active-low request lines, which are ranked 3 (highest) to 0. The arbiter answers with one active-low grant line per level. It then watches the active-low bus-busy line to confirm that the granted master has actually taken the bus. A two-bit mode input chooses how competing requests are resolved. In rotating mode the order changes after every grant. In single-level mode only one line is served. In fixed mode the highest level always wins.

A grant stays up until bus-busy is seen. If bus-busy does not show up within a chosen window of 16 µs or 256 µs, the grant is dropped and a sticky timeout flag is raised. Arbitration then starts again, so a dead or missing master cannot lock up the backplane. A parameter gives the number of clock cycles per microsecond, so both windows come out exact at any system clock rate.

Top module: `arb_bus_ctrl`

## Requirements
- R1: Request and bus-busy lines pass through one register stage before they are used. When the arbiter is idle and the bus is free, a request line driven low before clock edge N causes its grant line to go low right after edge N+1.
- R2: With mode 2'b10 or 2'b11 (fixed), the pending request with the highest level number is granted.
- R3: With mode 2'b01 (single-level), only level 3 is ever granted. Requests on levels 0 to 2 produce no grant at all.
- R4: With mode 2'b00 (rotating), the level served last has the lowest priority. The others are searched downward from the level just below it, wrapping from 0 to 3. After reset, level 3 is searched first.
- R5: At most one grant line is low at any time. A grant stays low until bus-busy is sampled low, and it is released on the next edge. No new grant is issued while the sampled bus-busy stays low.
- R6: If bus-busy is not seen, a grant is withdrawn after exactly 16×CYC_PER_US clocks when `tmo_long`=0, or 256×CYC_PER_US clocks when `tmo_long`=1. At the same time `tmo_flag` is set. The timed-out level counts as served, and arbitration resumes on the next cycle.
- R7: `tmo_flag` stays set until `tmo_clr` is sampled high on a clock edge. If a timeout and a clear fall on the same edge, the flag ends up set.
- R8: If bus-busy is sampled on the same edge on which the timeout window would expire, the bus is taken normally and no timeout is recorded.
- R9: While reset is asserted, and right after it is released, every grant line is high and `tmo_flag` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_n | input | NLVL | Active-low bus requests, bit index = level |
| bbsy_n | input | 1 | Active-low bus-busy from the current master |
| mode | input | 2 | 00 rotating, 01 single-level, 1x fixed priority |
| tmo_long | input | 1 | Timeout window select: 0 = 16 µs, 1 = 256 µs |
| tmo_clr | input | 1 | Clears the sticky timeout flag |
| grant_n | output | NLVL | Active-low bus grants, at most one low |
| tmo_flag | output | 1 | Sticky flag: a grant was not taken in time |

## Verification
Two events can land on the same edge. The first pair is bus-busy arriving and the timeout window expiring. The bench sweeps the arrival of bus-busy across the last few cycles of the short window, and on exactly one of those offsets the two coincide; the reference model decides whether a take-over or a timeout is expected. The second pair is a timeout and a flag clear. The bench holds `tmo_clr` high through a whole timeout, and the flag must appear for one cycle and then fall. All outputs are compared with the model on every cycle.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam logic [1:0] MODE_ROTATE = 2'b00;
  localparam logic [1:0] MODE_SINGLE = 2'b01;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_GRANT = 2'b01,
    ST_HELD  = 2'b10
  } arb_state_e;

endpackage

// File: rtl/arb_sync.sv
module arb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_n,
  output logic [W-1:0] act_q
);

  // Active-low lines are inverted and registered once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= ~din_n;
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import arb_pkg::*;
#(
  parameter int NLVL = 4,
  parameter int LW   = 2
) (
  input  logic [NLVL-1:0] req,
  input  logic [1:0]      mode,
  input  logic [LW-1:0]   last,
  output logic            valid,
  output logic [LW-1:0]   lvl
);

  always_comb begin
    valid = 1'b0;
    lvl   = '0;
    case (mode)
      MODE_SINGLE: begin
        if (req[NLVL-1]) begin
          valid = 1'b1;
          lvl   = LW'(NLVL-1);
        end
      end
      MODE_ROTATE: begin
        // Search downward from just below the last served level.
        for (int k = 1; k <= NLVL; k++) begin
          int idx;
          idx = (int'(last) + NLVL - k) % NLVL;
          if (!valid && req[idx]) begin
            valid = 1'b1;
            lvl   = LW'(idx);
          end
        end
      end
      default: begin
        for (int k = NLVL-1; k >= 0; k--) begin
          if (!valid && req[k]) begin
            valid = 1'b1;
            lvl   = LW'(k);
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/arb_timer.sv
module arb_timer #(
  parameter int CYC_PER_US = 100,
  parameter int SHORT_US   = 16,
  parameter int LONG_US    = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic long_sel,
  output logic expire
);

  localparam int SHORT_CYC = SHORT_US * CYC_PER_US;
  localparam int LONG_CYC  = LONG_US * CYC_PER_US;
  localparam int CW        = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_END = CW'(SHORT_CYC - 1);
  localparam logic [CW-1:0] LONG_END  = CW'(LONG_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] end_val;

  assign end_val = long_sel ? LONG_END : SHORT_END;

  always_comb begin
    cnt_d  = run ? cnt_q + 1'b1 : '0;
    expire = run && (cnt_q >= end_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/arb_bus_ctrl.sv
module arb_bus_ctrl
  import arb_pkg::*;
#(
  parameter int NLVL       = 4,
  parameter int CYC_PER_US = 100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NLVL-1:0] req_n,
  input  logic            bbsy_n,
  input  logic [1:0]      mode,
  input  logic            tmo_long,
  input  logic            tmo_clr,
  output logic [NLVL-1:0] grant_n,
  output logic            tmo_flag
);

  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1;

  logic [NLVL-1:0] req_s;
  logic            bbsy_s;
  logic            pick_valid;
  logic [LW-1:0]   pick_lvl;
  logic            expire;

  arb_state_e      state_q, state_d;
  logic [NLVL-1:0] gnt_q, gnt_d;
  logic [LW-1:0]   lvl_q, lvl_d;
  logic [LW-1:0]   last_q, last_d;
  logic            flag_q, flag_d;
  logic            gnt_en, last_en, flag_set;

  arb_sync #(.W(NLVL)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din_n (req_n),
    .act_q (req_s)
  );

  arb_sync #(.W(1)) u_bsy_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din_n (bbsy_n),
    .act_q (bbsy_s)
  );

  arb_pick #(.NLVL(NLVL), .LW(LW)) u_pick (
    .req   (req_s),
    .mode  (mode),
    .last  (last_q),
    .valid (pick_valid),
    .lvl   (pick_lvl)
  );

  arb_timer #(.CYC_PER_US(CYC_PER_US)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (state_q == ST_GRANT),
    .long_sel (tmo_long),
    .expire   (expire)
  );

  always_comb begin
    state_d  = state_q;
    gnt_d    = gnt_q;
    lvl_d    = lvl_q;
    last_d   = last_q;
    gnt_en   = 1'b0;
    last_en  = 1'b0;
    flag_set = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (!bbsy_s && pick_valid) begin
          state_d         = ST_GRANT;
          gnt_en          = 1'b1;
          gnt_d           = '0;
          gnt_d[pick_lvl] = 1'b1;
          lvl_d           = pick_lvl;
        end
      end
      ST_GRANT: begin
        if (bbsy_s) begin
          state_d = ST_HELD;
          gnt_en  = 1'b1;
          gnt_d   = '0;
          last_en = 1'b1;
          last_d  = lvl_q;
        end else if (expire) begin
          state_d  = ST_IDLE;
          gnt_en   = 1'b1;
          gnt_d    = '0;
          last_en  = 1'b1;
          last_d   = lvl_q;
          flag_set = 1'b1;
        end
      end
      ST_HELD: begin
        if (!bbsy_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
    flag_d = flag_set ? 1'b1 : (tmo_clr ? 1'b0 : flag_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gnt_q   <= '0;
      lvl_q   <= '0;
      last_q  <= '0;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
      if (gnt_en) begin
        gnt_q <= gnt_d;
        lvl_q <= lvl_d;
      end
      if (last_en) last_q <= last_d;
    end
  end

  assign grant_n  = ~gnt_q;
  assign tmo_flag = flag_q;

endmodule

// File: rtl/arb_bus_ctrl_chk.sv
module arb_bus_ctrl_chk #(
  parameter int NLVL = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bbsy_n,
  input logic [1:0]      mode,
  input logic            tmo_clr,
  input logic [NLVL-1:0] grant_n,
  input logic            tmo_flag
);

  localparam logic [NLVL-1:0] NONE = '1;

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~grant_n)); // R5

  AST_NO_GRANT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!bbsy_n && $past(!bbsy_n) && grant_n == NONE) |=> (grant_n == NONE)); // R5

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_n != NONE && $past(grant_n) != NONE) |-> $stable(grant_n)); // R5

  AST_SINGLE_TOP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && grant_n == NONE) |=> (grant_n[NLVL-2:0] == NONE[NLVL-2:0])); // R3

  AST_TMO_DROPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_flag) |-> (grant_n == NONE && $past(grant_n) != NONE)); // R6

  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_clr && grant_n == NONE) |=> !tmo_flag); // R7

endmodule

bind arb_bus_ctrl arb_bus_ctrl_chk #(.NLVL(NLVL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bbsy_n   (bbsy_n),
  .mode     (mode),
  .tmo_clr  (tmo_clr),
  .grant_n  (grant_n),
  .tmo_flag (tmo_flag)
);

// File: tb/arb_bus_ctrl_bench.sv
`timescale 1ns/1ps
module arb_bus_ctrl_bench;

  localparam int NLVL = 4;
  localparam int CPU  = 4;

  logic            clk;
  logic            rst_n;
  logic [NLVL-1:0] req_n;
  logic            bbsy_n;
  logic [1:0]      mode;
  logic            tmo_long;
  logic            tmo_clr;
  logic [NLVL-1:0] grant_n;
  logic            tmo_flag;

  arb_bus_ctrl #(.NLVL(NLVL), .CYC_PER_US(CPU)) u_arb_bus_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_n    (req_n),
    .bbsy_n   (bbsy_n),
    .mode     (mode),
    .tmo_long (tmo_long),
    .tmo_clr  (tmo_clr),
    .grant_n  (grant_n),
    .tmo_flag (tmo_flag)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    vectors = 0;
  int    misses  = 0;
  bit    done    = 0;
  string cur_req = "R9";

  // Behavioural reference model
  int       m_state;  // 0 idle, 1 granted, 2 bus held
  int       m_gnt;
  int       m_last;
  int       m_cnt;
  bit       m_flag;
  bit [3:0] m_req;
  bit       m_busy;

  function automatic int win_len();
    return tmo_long ? 256 * CPU : 16 * CPU;
  endfunction

  function automatic int choose();
    int order[$];
    if (mode == 2'b01) order.push_back(3);
    else if (mode == 2'b00)
      for (int k = 1; k <= 4; k++) order.push_back((m_last + 4 - k) % 4);
    else begin
      order.push_back(3); order.push_back(2);
      order.push_back(1); order.push_back(0);
    end
    foreach (order[i]) if (m_req[order[i]]) return order[i];
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_gnt = -1; m_last = 0; m_cnt = 0;
      m_flag = 0; m_req = '0; m_busy = 0;
    end else begin
      bit set_f;
      int p;
      set_f = 0;
      case (m_state)
        0: if (!m_busy) begin
             p = choose();
             if (p >= 0) begin m_state = 1; m_gnt = p; m_cnt = 0; end
           end
        1: if (m_busy) begin
             m_last = m_gnt; m_gnt = -1; m_state = 2;
           end else if (m_cnt >= win_len() - 1) begin
             m_last = m_gnt; m_gnt = -1; m_state = 0; set_f = 1;
           end else m_cnt++;
        default: if (!m_busy) m_state = 0;
      endcase
      if (set_f) m_flag = 1;
      else if (tmo_clr) m_flag = 0;
      m_req  = ~req_n;
      m_busy = !bbsy_n;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [3:0] exp_g;
      exp_g = 4'hF;
      if (m_gnt >= 0) exp_g[m_gnt] = 1'b0;
      vectors++;
      if (grant_n !== exp_g || tmo_flag !== m_flag) begin
        misses++;
        $display("FAIL %s t=%0t grant_n/flag actual=%b/%b expected=%b/%b",
                 cur_req, $time, grant_n, tmo_flag, exp_g, m_flag);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Wait for a grant, take the bus, optionally drop the request, release.
  task automatic serve(bit drop, int hold);
    int n = 0;
    int lvl = -1;
    while (grant_n == 4'hF && n < 3000) begin @(negedge clk); n++; end
    for (int i = 0; i < 4; i++) if (!grant_n[i]) lvl = i;
    cyc(1);
    bbsy_n = 1'b0;
    if (drop && lvl >= 0) req_n[lvl] = 1'b1;
    cyc(hold);
    bbsy_n = 1'b1;
    cyc(2);
  endtask

  initial begin
    rst_n = 1'b0; req_n = 4'hF; bbsy_n = 1'b1;
    mode = 2'b10; tmo_long = 1'b0; tmo_clr = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cur_req = "R9"; cyc(3);

    // R1: request-to-grant latency with a single requester
    cur_req = "R1";
    req_n = 4'b1011; serve(1, 3);
    req_n = 4'b1110; serve(1, 2);

    // R2: fixed priority, all pending, served one by one
    cur_req = "R2";
    mode = 2'b10; req_n = 4'b0000;
    for (int i = 0; i < 4; i++) serve(1, 3);
    mode = 2'b11; req_n = 4'b0101;
    for (int i = 0; i < 2; i++) serve(1, 2);

    // R4: rotating with all levels requesting continuously
    cur_req = "R4";
    mode = 2'b00; req_n = 4'b0000;
    for (int i = 0; i < 6; i++) serve(0, 2);
    req_n = 4'b1010;
    for (int i = 0; i < 3; i++) serve(0, 2);
    req_n = 4'hF; cyc(3);

    // R3: single-level ignores lower levels
    cur_req = "R3";
    mode = 2'b01; req_n = 4'b1000; cyc(20);
    req_n = 4'b0000; serve(1, 3);
    req_n = 4'hF; cyc(3);

    // R5: bus held long; other requests must wait
    cur_req = "R5";
    mode = 2'b10; req_n = 4'b1101; serve(1, 1);
    req_n = 4'b0110;
    serve(0, 15);
    req_n = 4'hF; cyc(3);

    // R6: short and long windows, no bus-busy
    cur_req = "R6";
    tmo_long = 1'b0; req_n = 4'b1101; cyc(16 * CPU + 6);
    req_n = 4'hF; cyc(3);
    tmo_clr = 1'b1; cyc(1); tmo_clr = 1'b0; cyc(2);
    tmo_long = 1'b1; req_n = 4'b0111; cyc(256 * CPU + 6);
    req_n = 4'hF; cyc(3);
    // rotating: timed-out level yields to the next
    mode = 2'b00; tmo_long = 1'b0; req_n = 4'b0011;
    cyc(2 * 16 * CPU + 10);
    req_n = 4'hF; cyc(3);

    // R7: clear held through a timeout, set must win for one cycle
    cur_req = "R7";
    tmo_clr = 1'b1; mode = 2'b10; req_n = 4'b1110;
    cyc(16 * CPU + 5);
    req_n = 4'hF; cyc(2);
    tmo_clr = 1'b0; cyc(2);

    // R8: bus-busy arrives around the last cycle of the window
    cur_req = "R8";
    for (int d = 16 * CPU - 4; d <= 16 * CPU; d++) begin
      req_n = 4'b1101;
      while (grant_n == 4'hF) @(negedge clk);
      cyc(d);
      bbsy_n = 1'b0; req_n = 4'hF;
      cyc(3);
      bbsy_n = 1'b1;
      cyc(2);
      tmo_clr = 1'b1; cyc(1); tmo_clr = 1'b0; cyc(2);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL %s watchdog actual=running expected=finished", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule